// File: doc/BRIEF.md
# FIFO Occupancy Watermark Monitor

This block sits beside a frame buffer FIFO and turns its fill level into evidence of overload. Every clock cycle it takes one sample of the level. Over a fixed observation window of a power-of-two number of samples it keeps the smallest level, the largest level and the running sum. At the end of the window it reports the floor average as a shift of the sum. It also reports a flag that says whether the window ever reached the high threshold. A clear input throws away a partial window and starts a new one.

Alongside the statistics it raises three kinds of event: a high-threshold crossing, a write into a full buffer, and the onset of backpressure. The crossing event uses hysteresis against a low threshold. Each event pulse comes with a free-running cycle timestamp and the level seen in that cycle. Events that occur together share one timestamp and one level. The FIFO itself and any readout path are outside the block.

Top module: `fifo_wm_monitor`

## Requirements
- R1: While reset is held, and on the first cycle after it, stat_vld_o, ev_hwm_o, ev_ovf_o and ev_bp_o are 0, and stat_min_o, stat_max_o, stat_avg_o, stat_hit_o, ev_ts_o and ev_lvl_o are 0.
- R2: One sample is taken per cycle. A window holds 2^WIN_LOG2 samples. stat_vld_o pulses for one cycle on the edge that takes the last sample of the window, and the next sample starts a new window. The first window starts with the first cycle after reset.
- R3: stat_min_o and stat_max_o equal the smallest and largest fill_lvl_i among the samples of the window that just closed.
- R4: stat_avg_o equals the sum of the window's samples shifted right by WIN_LOG2, which truncates. With ROUND=1 it rounds half up instead. The default is ROUND=0.
- R5: A cycle with win_clr_i high discards the partial window, and that cycle's sample becomes the first sample of the new window.
- R6: While armed, a sample with fill_lvl_i >= wm_hi_i gives one ev_hwm_o pulse and disarms the detector. The detector re-arms only after a sample with fill_lvl_i < wm_lo_i. The detector is armed after reset.
- R7: ev_ovf_o pulses for each cycle in which push_i=1, full_i=1 and pop_i=0. A push while full that is paired with a pop gives no event.
- R8: ev_bp_o pulses only in the cycle after bp_i goes from 0 to 1. A bp_i that stays high gives no further pulse.
- R9: Event pulses appear one cycle after the sampled cycle. ev_ts_o carries the timestamp counter value of that sampled cycle; the counter is 0 on the first cycle after reset and counts up by one each cycle. ev_lvl_o carries that cycle's fill_lvl_i. Both hold until the next event. Events in the same cycle share one ev_ts_o and one ev_lvl_o.
- R10: stat_hit_o is 1 when at least one sample of the closed window had fill_lvl_i >= wm_hi_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fill_lvl_i | input | LVL_W | FIFO occupancy sampled each cycle |
| push_i | input | 1 | Write strobe to the FIFO |
| pop_i | input | 1 | Read strobe from the FIFO |
| full_i | input | 1 | FIFO full flag |
| bp_i | input | 1 | Backpressure level from downstream |
| wm_lo_i | input | LVL_W | Low threshold that re-arms the high detector |
| wm_hi_i | input | LVL_W | High threshold |
| win_clr_i | input | 1 | Restart the observation window |
| stat_vld_o | output | 1 | Window-closed pulse |
| stat_min_o | output | LVL_W | Smallest level of the last window |
| stat_max_o | output | LVL_W | Largest level of the last window |
| stat_avg_o | output | LVL_W | Average level of the last window |
| stat_hit_o | output | 1 | Last window reached the high threshold |
| ev_hwm_o | output | 1 | High-threshold crossing event |
| ev_ovf_o | output | 1 | Write-while-full event |
| ev_bp_o | output | 1 | Backpressure onset event |
| ev_ts_o | output | TS_W | Timestamp of the latest event |
| ev_lvl_o | output | LVL_W | Fill level at the latest event |

## Verification
A high-threshold crossing and a write into a full buffer can occur in the same cycle. The two pulses then have to leave the block together with a single timestamp and level. The bench provokes this by driving a level above wm_hi_i while the detector is armed, in the same cycle as push with full and no pop. It then checks that both pulses are high on the next edge and that ev_ts_o and ev_lvl_o match that one cycle. A window close can also coincide with a clear request; the bench's window tests rely on the clear taking precedence and starting a fresh window.

// File: rtl/wmm_pkg.sv
package wmm_pkg;
   // one flag per event kind, raised in the sampled cycle
   typedef struct packed {
      logic hwm;
      logic ovf;
      logic bp;
   } wmm_evt_t;
endpackage

// File: rtl/wmm_stat_acc.sv
module wmm_stat_acc #(
   parameter int LVL_W    = 8,
   parameter int WIN_LOG2 = 4,
   parameter int ROUND    = 0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [LVL_W-1:0] lvl_i,
   input  logic [LVL_W-1:0] wm_hi_i,
   input  logic             clr_i,
   output logic             vld_o,
   output logic [LVL_W-1:0] min_o,
   output logic [LVL_W-1:0] max_o,
   output logic [LVL_W-1:0] avg_o,
   output logic             hit_o
);
   localparam int N     = 1 << WIN_LOG2;
   localparam int SUM_W = LVL_W + WIN_LOG2;

   logic [WIN_LOG2-1:0] cnt_q;
   logic [LVL_W-1:0]    min_q, max_q;
   logic [SUM_W-1:0]    sum_q;
   logic                hit_q;

   logic                first, close;
   logic [LVL_W-1:0]    min_n, max_n, avg_n;
   logic [SUM_W-1:0]    sum_n;
   logic                hit_n;

   always_comb begin
      first = clr_i || (cnt_q == '0);
      close = !clr_i && (&cnt_q);
      min_n = (first || (lvl_i < min_q)) ? lvl_i : min_q;
      max_n = (first || (lvl_i > max_q)) ? lvl_i : max_q;
      sum_n = (first ? '0 : sum_q) + SUM_W'(lvl_i);
      hit_n = (first ? 1'b0 : hit_q) | (lvl_i >= wm_hi_i);
   end

   generate
      if (ROUND != 0) begin : g_round
         logic [SUM_W:0] sum_r;
         always_comb begin
            sum_r = {1'b0, sum_n} + (SUM_W+1)'(N / 2);
            avg_n = LVL_W'(sum_r >> WIN_LOG2);
         end
      end else begin : g_trunc
         always_comb avg_n = LVL_W'(sum_n >> WIN_LOG2);
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         min_q <= '0;
         max_q <= '0;
         sum_q <= '0;
         hit_q <= 1'b0;
         vld_o <= 1'b0;
         min_o <= '0;
         max_o <= '0;
         avg_o <= '0;
         hit_o <= 1'b0;
      end else begin
         cnt_q <= clr_i ? WIN_LOG2'(1) : cnt_q + 1'b1;
         min_q <= min_n;
         max_q <= max_n;
         sum_q <= sum_n;
         hit_q <= hit_n;
         vld_o <= close;
         if (close) begin
            min_o <= min_n;
            max_o <= max_n;
            avg_o <= avg_n;
            hit_o <= hit_n;
         end
      end
   end

   // R3 / R4: a reported window is ordered min <= avg <= max
   a_r3_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_o |-> (min_o <= avg_o) && (avg_o <= max_o));
   // R2: a window of two or more samples cannot close twice in a row
   a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_o |=> !vld_o);
   // R5: a clear never closes a window on the next edge
   a_r5_clr_no_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> !vld_o);
endmodule

// File: rtl/wmm_hyst_det.sv
module wmm_hyst_det #(
   parameter int LVL_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [LVL_W-1:0] lvl_i,
   input  logic [LVL_W-1:0] wm_lo_i,
   input  logic [LVL_W-1:0] wm_hi_i,
   output logic             fire_o
);
   logic armed_q;

   assign fire_o = armed_q && (lvl_i >= wm_hi_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        armed_q <= 1'b1;
      else if (fire_o)                    armed_q <= 1'b0;
      else if (!armed_q && lvl_i < wm_lo_i) armed_q <= 1'b1;
   end

   // R6: a crossing fires once, never on two consecutive cycles
   a_r6_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_o |=> !fire_o);
   // R6: a disarmed detector stays disarmed while the level is not below low
   a_r6_stay_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!armed_q && (lvl_i >= wm_lo_i)) |=> !armed_q);
endmodule

// File: rtl/wmm_evt_tag.sv
module wmm_evt_tag
   import wmm_pkg::*;
#(
   parameter int LVL_W = 8,
   parameter int TS_W  = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  wmm_evt_t         evt_i,
   input  logic [LVL_W-1:0] lvl_i,
   output logic             hwm_o,
   output logic             ovf_o,
   output logic             bp_o,
   output logic [TS_W-1:0]  ts_o,
   output logic [LVL_W-1:0] lvl_o
);
   logic [TS_W-1:0] ts_q;
   logic            any_in, any_out;

   assign any_in  = evt_i.hwm | evt_i.ovf | evt_i.bp;
   assign any_out = hwm_o | ovf_o | bp_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ts_q  <= '0;
         hwm_o <= 1'b0;
         ovf_o <= 1'b0;
         bp_o  <= 1'b0;
         ts_o  <= '0;
         lvl_o <= '0;
      end else begin
         ts_q  <= ts_q + 1'b1;
         hwm_o <= evt_i.hwm;
         ovf_o <= evt_i.ovf;
         bp_o  <= evt_i.bp;
         if (any_in) begin
            ts_o  <= ts_q;
            lvl_o <= lvl_i;
         end
      end
   end

   // R9: events on back-to-back cycles carry timestamps one apart
   a_r9_ts_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (any_out && $past(any_out)) |-> (ts_o == TS_W'($past(ts_o) + 1'b1)));
   // R9: tag holds while no event is raised
   a_r9_tag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !any_in |=> ($stable(ts_o) && $stable(lvl_o)));
endmodule

// File: rtl/fifo_wm_monitor.sv
module fifo_wm_monitor
   import wmm_pkg::*;
#(
   parameter int LVL_W    = 8,
   parameter int TS_W     = 16,
   parameter int WIN_LOG2 = 4,
   parameter int ROUND    = 0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [LVL_W-1:0] fill_lvl_i,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic             full_i,
   input  logic             bp_i,
   input  logic [LVL_W-1:0] wm_lo_i,
   input  logic [LVL_W-1:0] wm_hi_i,
   input  logic             win_clr_i,
   output logic             stat_vld_o,
   output logic [LVL_W-1:0] stat_min_o,
   output logic [LVL_W-1:0] stat_max_o,
   output logic [LVL_W-1:0] stat_avg_o,
   output logic             stat_hit_o,
   output logic             ev_hwm_o,
   output logic             ev_ovf_o,
   output logic             ev_bp_o,
   output logic [TS_W-1:0]  ev_ts_o,
   output logic [LVL_W-1:0] ev_lvl_o
);
   generate
      if (LVL_W < 2)          begin : g_bad_lvl   $error("LVL_W must be at least 2");        end
      if (TS_W < 2)           begin : g_bad_ts    $error("TS_W must be at least 2");         end
      if (WIN_LOG2 < 1 || WIN_LOG2 > 24)
                              begin : g_bad_win   $error("WIN_LOG2 must be 1 to 24");        end
      if (ROUND < 0 || ROUND > 1)
                              begin : g_bad_round $error("ROUND must be 0 or 1");            end
   endgenerate

   logic     bp_q;
   wmm_evt_t evt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bp_q <= 1'b0;
      else         bp_q <= bp_i;
   end

   assign evt.ovf = push_i && full_i && !pop_i;
   assign evt.bp  = bp_i && !bp_q;

   wmm_hyst_det #(.LVL_W(LVL_W)) u_hyst (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .lvl_i   (fill_lvl_i),
      .wm_lo_i (wm_lo_i),
      .wm_hi_i (wm_hi_i),
      .fire_o  (evt.hwm)
   );

   wmm_stat_acc #(.LVL_W(LVL_W), .WIN_LOG2(WIN_LOG2), .ROUND(ROUND)) u_stat (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .lvl_i   (fill_lvl_i),
      .wm_hi_i (wm_hi_i),
      .clr_i   (win_clr_i),
      .vld_o   (stat_vld_o),
      .min_o   (stat_min_o),
      .max_o   (stat_max_o),
      .avg_o   (stat_avg_o),
      .hit_o   (stat_hit_o)
   );

   wmm_evt_tag #(.LVL_W(LVL_W), .TS_W(TS_W)) u_tag (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   (evt),
      .lvl_i   (fill_lvl_i),
      .hwm_o   (ev_hwm_o),
      .ovf_o   (ev_ovf_o),
      .bp_o    (ev_bp_o),
      .ts_o    (ev_ts_o),
      .lvl_o   (ev_lvl_o)
   );

   // R7: a push into a full buffer without a pop is always reported
   a_r7_ovf_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_i && full_i && !pop_i) |=> ev_ovf_o);
   // R7: a paired push and pop is never an overflow
   a_r7_pair_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_i && pop_i) |=> !ev_ovf_o);
   // R8: backpressure that was already high gives no onset event
   a_r8_level_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bp_i && $past(bp_i)) |=> !ev_bp_o);
endmodule

// File: tb/test_fifo_wm_monitor.sv
module test_fifo_wm_monitor;
   localparam int LVL_W = 8;
   localparam int TS_W  = 16;
   localparam int WLOG  = 4;
   localparam int N     = 1 << WLOG;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [LVL_W-1:0] lvl = '0, wm_lo = '0, wm_hi = '1;
   logic             push = 0, pop = 0, full = 0, bp = 0, clr = 0;
   logic             s_vld, s_hit, e_hwm, e_ovf, e_bp;
   logic [LVL_W-1:0] s_min, s_max, s_avg, e_lvl;
   logic [TS_W-1:0]  e_ts;

   int checks = 0;
   int errors = 0;
   int tb_cyc = 0;

   always #10 clk = ~clk;

   always @(posedge clk) if (rst_n) tb_cyc <= tb_cyc + 1;

   fifo_wm_monitor #(.LVL_W(LVL_W), .TS_W(TS_W), .WIN_LOG2(WLOG), .ROUND(0)) i_fifo_wm_monitor (
      .clk_i(clk), .rst_ni(rst_n), .fill_lvl_i(lvl), .push_i(push), .pop_i(pop),
      .full_i(full), .bp_i(bp), .wm_lo_i(wm_lo), .wm_hi_i(wm_hi), .win_clr_i(clr),
      .stat_vld_o(s_vld), .stat_min_o(s_min), .stat_max_o(s_max), .stat_avg_o(s_avg),
      .stat_hit_o(s_hit), .ev_hwm_o(e_hwm), .ev_ovf_o(e_ovf), .ev_bp_o(e_bp),
      .ev_ts_o(e_ts), .ev_lvl_o(e_lvl));

   task automatic chk(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      chk("R1 stat_vld in reset", s_vld, 0);
      chk("R1 stat_min in reset", s_min, 0);
      chk("R1 events in reset", {e_hwm, e_ovf, e_bp}, 0);
      chk("R1 ev_ts in reset", e_ts, 0);
      rst_n = 1'b1;
      step();
      chk("R1 no event after reset", {e_hwm, e_ovf, e_bp, s_vld}, 0);
      chk("R1 stat_avg after reset", s_avg, 0);
   endtask

   // runs one window started by clear, checks R2 R3 R4 R10
   task automatic t_window(input string tag, input int mul, input int add, input int hi);
      int mn = 255, mx = 0, sum = 0, hit = 0;
      wm_hi = LVL_W'(hi);
      for (int i = 0; i < N; i++) begin
         int v = (i * mul + add) % 256;
         lvl = LVL_W'(v);
         clr = (i == 0);
         if (v < mn) mn = v;
         if (v > mx) mx = v;
         if (v >= hi) hit = 1;
         sum += v;
         step();
         if (i < N - 1 && s_vld) chk({"R2 early close ", tag}, 1, 0);
      end
      clr = 0;
      chk({"R2 close pulse ", tag}, s_vld, 1);
      chk({"R3 min ", tag}, s_min, mn);
      chk({"R3 max ", tag}, s_max, mx);
      chk({"R4 avg ", tag}, s_avg, sum / N);
      chk({"R10 hit ", tag}, s_hit, hit);
      step();
      chk({"R2 pulse width ", tag}, s_vld, 0);
   endtask

   task automatic t_clear();
      lvl = 8'd250;
      for (int i = 0; i < 5; i++) step();
      t_window("after clear R5", 0, 7, 255);
   endtask

   task automatic t_hyst();
      wm_lo = 8'd20; wm_hi = 8'd50;
      lvl = 8'd10; step(); step();
      lvl = 8'd50; step();
      chk("R6 crossing fires", e_hwm, 1);
      chk("R9 hwm timestamp", e_ts, tb_cyc - 1);
      chk("R9 hwm level", e_lvl, 50);
      lvl = 8'd60; step();
      chk("R6 no refire while high", e_hwm, 0);
      lvl = 8'd30; step();
      lvl = 8'd60; step();
      chk("R6 no rearm between thresholds", e_hwm, 0);
      chk("R9 tag holds", e_lvl, 50);
      lvl = 8'd19; step();
      lvl = 8'd55; step();
      chk("R6 refire after rearm", e_hwm, 1);
      lvl = 8'd10; step(); step();
   endtask

   task automatic t_ovf();
      full = 1; push = 1; pop = 0; lvl = 8'd12; step();
      chk("R7 push while full", e_ovf, 1);
      chk("R9 ovf timestamp", e_ts, tb_cyc - 1);
      chk("R9 ovf level", e_lvl, 12);
      pop = 1; step();
      chk("R7 push with pop while full", e_ovf, 0);
      full = 0; pop = 0; step();
      chk("R7 push not full", e_ovf, 0);
      push = 0; step();
   endtask

   task automatic t_bp();
      bp = 1; lvl = 8'd9; step();
      chk("R8 backpressure onset", e_bp, 1);
      chk("R9 bp timestamp", e_ts, tb_cyc - 1);
      step();
      chk("R8 held backpressure quiet", e_bp, 0);
      step();
      chk("R8 still quiet", e_bp, 0);
      bp = 0; step();
      chk("R8 fall quiet", e_bp, 0);
      bp = 1; step();
      chk("R8 second onset", e_bp, 1);
      bp = 0; step();
   endtask

   task automatic t_same_cycle();
      wm_lo = 8'd20; wm_hi = 8'd50;
      lvl = 8'd5; step();
      lvl = 8'd77; push = 1; full = 1; pop = 0; step();
      chk("R9 both pulses", {e_hwm, e_ovf}, 3);
      chk("R9 shared timestamp", e_ts, tb_cyc - 1);
      chk("R9 shared level", e_lvl, 77);
      push = 0; full = 0; lvl = 8'd5; step();
      chk("R9 pulses drop", {e_hwm, e_ovf}, 0);
   endtask

   initial begin
      step(); step();
      t_reset();
      t_window("ramp", 1, 3, 200);
      t_window("scatter", 53, 7, 100);
      t_clear();
      t_hyst();
      t_ovf();
      t_bp();
      t_same_cycle();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule